// File: doc/BRIEF.md
# CCD Readout Line Sequencer

This block produces the line-level timing for reading out an interline CCD. It runs from the pixel-rate clock and divides time into line periods of a fixed number of cycles. It groups those line periods into fields. For every line period it reports the sensor line being shifted out, the field it belongs to, and whether the line carries valid pixels. Inside each line it raises a horizontal sync at the start, then marks the horizontal dummy cycles, the pixel window and the optical-black columns at both edges of that window.

Two readout schedules are available. The full schedule reads every line across two interlaced fields. The first field carries the odd lines. The second field starts with one dummy line and then carries the even lines. The fast schedule uses a single short field and outputs two lines out of every group of eight, starting at line 5. It stops after a fixed number of lines, and the rest of that field is blank. The schedule select input is sampled only at field starts, so a request made during a field waits for the next vertical sync.

Top module: `ccd_line_seq`

## Requirements
- R1: While the synchronous active-high reset is held, every output is 0. After release the block starts at line 1 of the first field using the full schedule, and the first line period begins at the first clock edge after release. All outputs are registered, so each one reflects the counter state of the previous cycle.
- R2: A line period is LINE_CYC cycles long. `hs_o` is high for the first `hs_width` cycles of each line period. It is never high when `hs_width` is 0, and it stays high for the whole period when `hs_width` is at least LINE_CYC.
- R3: In the full schedule the first field (`field_o`=0) puts out lines 1, 3, 5, … LINES-1 in consecutive line periods, starting with the field's first period, with `lv_o`=1. The remaining periods of the field are blank.
- R4: In the full schedule the second field (`field_o`=1) opens with one dummy line, during which `vdum_o`=1 and `lv_o`=0. It then puts out lines 2, 4, … LINES in consecutive periods.
- R5: A full-schedule field lasts FIELD_LEN line periods, and the two fields alternate. `vs_o` is high for the entire first line period of every field.
- R6: When `fast_sel`=1 is in effect (`fast_o`=1), each field lasts FAST_LEN line periods and has `field_o`=0. The n-th line period (n counted from 0) carries sensor line FAST_START + GROUP·⌊n/KEEP⌋ + (n mod KEEP). Exactly FAST_COUNT such lines are put out, and the rest of the field is blank.
- R7: `fast_sel` (0 = full, 1 = fast) is taken only at the end of the last line period of a field, so `fast_o` changes only together with a rising `vs_o`. A switch to the full schedule always begins with the first field.
- R8: During any line period with `lv_o`=0, `line_o` is 0.
- R9: `hdum_o` is high for HDUMMY cycles, starting H_START cycles after the line period begins.
- R10: `hwin_o` is high for the TOTAL_PIX cycles that follow the dummy cycles. `hob_o` is high during the first OB_FRONT and the last OB_REAR of those cycles, and at no other time.
- R11: `vob_o` is high during valid lines whose number is at most VOB_FRONT or greater than LINES-VOB_REAR. It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| fast_sel | input | 1 | Schedule request: 0 full, 1 fast |
| hs_width | input | PXW+1 | Horizontal sync length in cycles |
| hs_o | output | 1 | Horizontal sync |
| vs_o | output | 1 | Vertical sync, first line period of a field |
| lv_o | output | 1 | Line carries valid pixels |
| line_o | output | LINE_W | Sensor line number, 0 when not valid |
| field_o | output | 1 | Field identifier, 1 for the second full-schedule field |
| fast_o | output | 1 | Fast schedule in effect |
| hdum_o | output | 1 | Horizontal dummy cycles |
| hwin_o | output | 1 | Pixel window |
| hob_o | output | 1 | Optical-black column |
| vob_o | output | 1 | Optical-black line |
| vdum_o | output | 1 | Vertical dummy line |

## Verification
The assertions allow `fast_sel` to change in any cycle, because the block samples it only at field ends. They check the sync relation only while `hs_width` is nonzero. They also rely on the parameters fitting together: every field must be longer than the lines it carries, and the horizontal window must fit inside a line period. The stimulus uses a reduced, consistent parameter set so that whole frames can be swept cycle by cycle. It changes the schedule request in the middle of fields, runs three sync lengths (zero, short and a full line), and applies a reset in the middle of a field while the fast schedule is requested.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic {
    MODE_FULL = 1'b0,
    MODE_FAST = 1'b1
  } rd_mode_e;

  typedef struct packed {
    logic sync;
    logic dummy;
    logic win;
    logic ob;
  } hflag_t;

endpackage

// File: rtl/ccd_hcount.sv
module ccd_hcount
  import ccd_seq_pkg::*;
#(
  parameter int LINE_CYC  = 1560,
  parameter int H_START   = 100,
  parameter int HDUMMY    = 30,
  parameter int TOTAL_PIX = 1343,
  parameter int OB_FRONT  = 3,
  parameter int OB_REAR   = 50,
  parameter int PXW       = $clog2(LINE_CYC)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [PXW:0]   hs_width,
  output logic           eol_o,
  output logic           sol_o,
  output hflag_t         flags_o
);

  localparam logic [PXW:0] P_LAST = (PXW+1)'(LINE_CYC - 1);
  localparam logic [PXW:0] P_DLO  = (PXW+1)'(H_START);
  localparam logic [PXW:0] P_WLO  = (PXW+1)'(H_START + HDUMMY);
  localparam logic [PXW:0] P_WHI  = (PXW+1)'(H_START + HDUMMY + TOTAL_PIX);
  localparam logic [PXW:0] P_OLO  = (PXW+1)'(H_START + HDUMMY + OB_FRONT);
  localparam logic [PXW:0] P_OHI  = (PXW+1)'(H_START + HDUMMY + TOTAL_PIX - OB_REAR);

  logic [PXW-1:0] px_q;
  logic [PXW:0]   pxe;

  assign pxe   = {1'b0, px_q};
  assign eol_o = (pxe == P_LAST);
  assign sol_o = (px_q == '0);

  always_ff @(posedge clk) begin
    if (rst || eol_o) px_q <= '0;
    else              px_q <= px_q + PXW'(1);
  end

  always_comb begin
    flags_o.sync  = (pxe < hs_width);
    flags_o.dummy = (pxe >= P_DLO) && (pxe < P_WLO);
    flags_o.win   = (pxe >= P_WLO) && (pxe < P_WHI);
    flags_o.ob    = flags_o.win && ((pxe < P_OLO) || (pxe >= P_OHI));
  end

endmodule

// File: rtl/ccd_vsched.sv
module ccd_vsched
  import ccd_seq_pkg::*;
#(
  parameter int LINES      = 966,
  parameter int FIELD_LEN  = 525,
  parameter int FAST_LEN   = 262,
  parameter int FAST_START = 5,
  parameter int GROUP      = 8,
  parameter int KEEP       = 2,
  parameter int FAST_COUNT = 241,
  parameter int VOB_FRONT  = 4,
  parameter int VOB_REAR   = 2,
  parameter int LW         = $clog2(2*FIELD_LEN + FAST_START + GROUP*FAST_LEN + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          eol,
  input  logic          fast_sel,
  output rd_mode_e      mode_o,
  output logic          field_o,
  output logic          sof_o,
  output logic          valid_o,
  output logic          vdum_o,
  output logic          vob_o,
  output logic [LW-1:0] line_o
);

  localparam int HALF      = LINES / 2;
  localparam int SLOTS_MAX = (FIELD_LEN > FAST_LEN) ? FIELD_LEN : FAST_LEN;
  localparam int SW        = $clog2(SLOTS_MAX + 1);

  localparam logic [SW-1:0] S_FULL_END = SW'(FIELD_LEN - 1);
  localparam logic [SW-1:0] S_FAST_END = SW'(FAST_LEN - 1);
  localparam logic [SW-1:0] S_HALF     = SW'(HALF);
  localparam logic [SW-1:0] S_FCNT     = SW'(FAST_COUNT);
  localparam logic [LW-1:0] L_ONE      = LW'(1);
  localparam logic [LW-1:0] L_TWO      = LW'(2);
  localparam logic [LW-1:0] L_FS       = LW'(FAST_START);
  localparam logic [LW-1:0] L_JUMP     = LW'(GROUP - KEEP + 1);
  localparam logic [LW-1:0] L_VOBF     = LW'(VOB_FRONT);
  localparam logic [LW-1:0] L_VOBR     = LW'(LINES - VOB_REAR);

  rd_mode_e      mode_q;
  rd_mode_e      mode_req;
  logic          field_q;
  logic [SW-1:0] slot_q;
  logic [LW-1:0] line_q;
  logic [LW-1:0] line_step;
  logic          slot_last;
  logic          field_nxt;
  logic          keep_wrap;

  assign mode_req  = rd_mode_e'(fast_sel);
  assign slot_last = (mode_q == MODE_FAST) ? (slot_q == S_FAST_END) : (slot_q == S_FULL_END);
  assign field_nxt = (mode_q == MODE_FULL) && (mode_req == MODE_FULL) && !field_q;

  generate
    if (KEEP > 1) begin : g_keep_cnt
      localparam int KW = $clog2(KEEP);
      localparam logic [KW-1:0] K_LAST = KW'(KEEP - 1);
      logic [KW-1:0] keep_q;
      assign keep_wrap = (keep_q == K_LAST);
      always_ff @(posedge clk) begin
        if (rst)                        keep_q <= '0;
        else if (eol && slot_last)      keep_q <= '0;
        else if (eol && keep_wrap)      keep_q <= '0;
        else if (eol)                   keep_q <= keep_q + KW'(1);
      end
    end else begin : g_keep_one
      assign keep_wrap = 1'b1;
    end
  endgenerate

  always_comb begin
    if (mode_q == MODE_FAST)
      line_step = keep_wrap ? (line_q + L_JUMP) : (line_q + L_ONE);
    else if (field_q && (slot_q == '0))
      line_step = L_TWO;
    else
      line_step = line_q + L_TWO;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_FULL;
      field_q <= 1'b0;
      slot_q  <= '0;
      line_q  <= L_ONE;
    end else if (eol) begin
      if (slot_last) begin
        mode_q  <= mode_req;
        field_q <= field_nxt;
        slot_q  <= '0;
        if (mode_req == MODE_FAST) line_q <= L_FS;
        else if (field_nxt)        line_q <= '0;
        else                       line_q <= L_ONE;
      end else begin
        slot_q <= slot_q + SW'(1);
        line_q <= line_step;
      end
    end
  end

  always_comb begin
    if (mode_q == MODE_FAST)  valid_o = (slot_q < S_FCNT);
    else if (!field_q)        valid_o = (slot_q < S_HALF);
    else                      valid_o = (slot_q != '0) && (slot_q <= S_HALF);
  end

  assign mode_o  = mode_q;
  assign field_o = field_q;
  assign sof_o   = (slot_q == '0);
  assign vdum_o  = (mode_q == MODE_FULL) && field_q && (slot_q == '0);
  assign vob_o   = valid_o && ((line_q <= L_VOBF) || (line_q > L_VOBR));
  assign line_o  = line_q;

endmodule

// File: rtl/ccd_line_seq.sv
module ccd_line_seq
  import ccd_seq_pkg::*;
#(
  parameter int LINE_CYC   = 1560,
  parameter int H_START    = 100,
  parameter int HDUMMY     = 30,
  parameter int TOTAL_PIX  = 1343,
  parameter int OB_FRONT   = 3,
  parameter int OB_REAR    = 50,
  parameter int LINES      = 966,
  parameter int FIELD_LEN  = 525,
  parameter int FAST_LEN   = 262,
  parameter int FAST_START = 5,
  parameter int GROUP      = 8,
  parameter int KEEP       = 2,
  parameter int FAST_COUNT = 241,
  parameter int VOB_FRONT  = 4,
  parameter int VOB_REAR   = 2,
  localparam int PXW       = $clog2(LINE_CYC),
  localparam int LINE_W    = $clog2(LINES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fast_sel,
  input  logic [PXW:0]      hs_width,
  output logic              hs_o,
  output logic              vs_o,
  output logic              lv_o,
  output logic [LINE_W-1:0] line_o,
  output logic              field_o,
  output logic              fast_o,
  output logic              hdum_o,
  output logic              hwin_o,
  output logic              hob_o,
  output logic              vob_o,
  output logic              vdum_o
);

  localparam int LW = $clog2(2*FIELD_LEN + FAST_START + GROUP*FAST_LEN + 2);

  logic          eol;
  logic          sol;
  hflag_t        hf;
  rd_mode_e      mode;
  logic          fld;
  logic          sof;
  logic          vld;
  logic          vdum;
  logic          vob;
  logic [LW-1:0] lnum;

  ccd_hcount #(
    .LINE_CYC (LINE_CYC),
    .H_START  (H_START),
    .HDUMMY   (HDUMMY),
    .TOTAL_PIX(TOTAL_PIX),
    .OB_FRONT (OB_FRONT),
    .OB_REAR  (OB_REAR),
    .PXW      (PXW)
  ) u_hcount (
    .clk     (clk),
    .rst     (rst),
    .hs_width(hs_width),
    .eol_o   (eol),
    .sol_o   (sol),
    .flags_o (hf)
  );

  ccd_vsched #(
    .LINES     (LINES),
    .FIELD_LEN (FIELD_LEN),
    .FAST_LEN  (FAST_LEN),
    .FAST_START(FAST_START),
    .GROUP     (GROUP),
    .KEEP      (KEEP),
    .FAST_COUNT(FAST_COUNT),
    .VOB_FRONT (VOB_FRONT),
    .VOB_REAR  (VOB_REAR),
    .LW        (LW)
  ) u_vsched (
    .clk     (clk),
    .rst     (rst),
    .eol     (eol),
    .fast_sel(fast_sel),
    .mode_o  (mode),
    .field_o (fld),
    .sof_o   (sof),
    .valid_o (vld),
    .vdum_o  (vdum),
    .vob_o   (vob),
    .line_o  (lnum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_o    <= 1'b0;
      vs_o    <= 1'b0;
      lv_o    <= 1'b0;
      line_o  <= '0;
      field_o <= 1'b0;
      fast_o  <= 1'b0;
      hdum_o  <= 1'b0;
      hwin_o  <= 1'b0;
      hob_o   <= 1'b0;
      vob_o   <= 1'b0;
      vdum_o  <= 1'b0;
    end else begin
      hs_o    <= hf.sync;
      vs_o    <= sof;
      lv_o    <= vld;
      line_o  <= vld ? lnum[LINE_W-1:0] : '0;
      field_o <= fld;
      fast_o  <= (mode == MODE_FAST);
      hdum_o  <= hf.dummy;
      hwin_o  <= hf.win;
      hob_o   <= hf.ob;
      vob_o   <= vob;
      vdum_o  <= vdum;
    end
  end

  logic unused_sol;
  assign unused_sol = sol;

endmodule

// File: rtl/ccd_line_seq_chk.sv
module ccd_line_seq_chk (
  input logic clk,
  input logic rst,
  input logic hsw_nz,
  input logic hs_o,
  input logic vs_o,
  input logic lv_o,
  input logic line_nz,
  input logic field_o,
  input logic fast_o,
  input logic hdum_o,
  input logic hwin_o,
  input logic hob_o,
  input logic vob_o,
  input logic vdum_o
);

  AST_HS_WITH_VS: assert property (@(posedge clk) disable iff (rst)
    (hsw_nz && $rose(vs_o)) |-> hs_o);                           // R2

  AST_VALID_HAS_LINE: assert property (@(posedge clk) disable iff (rst)
    lv_o |-> line_nz);                                           // R8

  AST_VDUM_SECOND_FIELD: assert property (@(posedge clk) disable iff (rst)
    vdum_o |-> (field_o && !lv_o && vs_o));                      // R4

  AST_FAST_SINGLE_FIELD: assert property (@(posedge clk) disable iff (rst)
    fast_o |-> !field_o && !vdum_o);                             // R6

  AST_MODE_AT_VS: assert property (@(posedge clk) disable iff (rst)
    (fast_o != $past(fast_o)) |-> $rose(vs_o));                  // R7

  AST_DUMMY_OUTSIDE_WIN: assert property (@(posedge clk) disable iff (rst)
    hdum_o |-> !hwin_o);                                         // R9

  AST_OB_INSIDE_WIN: assert property (@(posedge clk) disable iff (rst)
    hob_o |-> hwin_o);                                           // R10

  AST_VOB_ON_VALID: assert property (@(posedge clk) disable iff (rst)
    vob_o |-> lv_o);                                             // R11

endmodule

bind ccd_line_seq ccd_line_seq_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .hsw_nz (|hs_width),
  .hs_o   (hs_o),
  .vs_o   (vs_o),
  .lv_o   (lv_o),
  .line_nz(|line_o),
  .field_o(field_o),
  .fast_o (fast_o),
  .hdum_o (hdum_o),
  .hwin_o (hwin_o),
  .hob_o  (hob_o),
  .vob_o  (vob_o),
  .vdum_o (vdum_o)
);

// File: tb/ccd_line_seq_tb.sv
module ccd_line_seq_tb;

  localparam int LC  = 40;
  localparam int HS  = 4;
  localparam int HD  = 3;
  localparam int TP  = 20;
  localparam int OBF = 2;
  localparam int OBR = 3;
  localparam int LN  = 10;
  localparam int FDL = 7;
  localparam int FL  = 5;
  localparam int FS  = 3;
  localparam int GR  = 4;
  localparam int KP  = 2;
  localparam int FC  = 3;
  localparam int VF  = 1;
  localparam int VR  = 1;
  localparam int PXW = $clog2(LC);
  localparam int LNW = $clog2(LN + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fast_sel = 1'b0;
  logic [PXW:0] hs_width = (PXW+1)'(5);
  logic hs_o, vs_o, lv_o, field_o, fast_o, hdum_o, hwin_o, hob_o, vob_o, vdum_o;
  logic [LNW-1:0] line_o;

  always #10 clk = ~clk;

  ccd_line_seq #(
    .LINE_CYC(LC), .H_START(HS), .HDUMMY(HD), .TOTAL_PIX(TP),
    .OB_FRONT(OBF), .OB_REAR(OBR), .LINES(LN), .FIELD_LEN(FDL),
    .FAST_LEN(FL), .FAST_START(FS), .GROUP(GR), .KEEP(KP),
    .FAST_COUNT(FC), .VOB_FRONT(VF), .VOB_REAR(VR)
  ) u_dut (
    .clk(clk), .rst(rst), .fast_sel(fast_sel), .hs_width(hs_width),
    .hs_o(hs_o), .vs_o(vs_o), .lv_o(lv_o), .line_o(line_o),
    .field_o(field_o), .fast_o(fast_o), .hdum_o(hdum_o), .hwin_o(hwin_o),
    .hob_o(hob_o), .vob_o(vob_o), .vdum_o(vdum_o)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Model state: counters of the line period in progress
  int m_px, m_slot, m_field, m_mode;
  int e_hs, e_vs, e_lv, e_line, e_field, e_fast, e_hdum, e_hwin, e_hob, e_vob, e_vdum;
  string e_ltag;
  bit e_rst;

  always @(posedge clk) begin
    if (rst) begin
      m_px = 0; m_slot = 0; m_field = 0; m_mode = 0;
      e_hs = 0; e_vs = 0; e_lv = 0; e_line = 0; e_field = 0; e_fast = 0;
      e_hdum = 0; e_hwin = 0; e_hob = 0; e_vob = 0; e_vdum = 0;
      e_ltag = "R1"; e_rst = 1'b1;
    end else begin
      int p;
      e_rst  = 1'b0;
      e_hs   = (m_px < int'(hs_width)) ? 1 : 0;
      e_vs   = (m_slot == 0) ? 1 : 0;
      e_fast = m_mode;
      e_field = (m_mode == 0) ? m_field : 0;
      if (m_mode == 1) begin
        e_lv = (m_slot < FC) ? 1 : 0;
        e_line = FS + GR * (m_slot / KP) + (m_slot % KP);
        e_ltag = "R6";
      end else if (m_field == 0) begin
        e_lv = (m_slot < LN / 2) ? 1 : 0;
        e_line = 2 * m_slot + 1;
        e_ltag = "R3";
      end else begin
        e_lv = (m_slot >= 1 && m_slot <= LN / 2) ? 1 : 0;
        e_line = 2 * m_slot;
        e_ltag = "R4";
      end
      if (e_lv == 0) begin
        e_line = 0;
        e_ltag = "R8";
      end
      e_vdum = (m_mode == 0 && m_field == 1 && m_slot == 0) ? 1 : 0;
      e_vob  = (e_lv == 1 && (e_line <= VF || e_line > LN - VR)) ? 1 : 0;
      e_hdum = (m_px >= HS && m_px < HS + HD) ? 1 : 0;
      e_hwin = (m_px >= HS + HD && m_px < HS + HD + TP) ? 1 : 0;
      p = m_px - HS - HD;
      e_hob  = (e_hwin == 1 && (p < OBF || p >= TP - OBR)) ? 1 : 0;
      // advance
      m_px++;
      if (m_px == LC) begin
        m_px = 0;
        if (m_slot == ((m_mode == 1) ? FL - 1 : FDL - 1)) begin
          m_field = (m_mode == 0 && fast_sel == 1'b0 && m_field == 0) ? 1 : 0;
          m_mode  = fast_sel ? 1 : 0;
          m_slot  = 0;
        end else begin
          m_slot++;
        end
      end
    end
  end

  task automatic chk(string tag, string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, nm, act, exp, $time);
    end
  endtask

  // R1 reset values, then per-cycle comparison of every output
  always @(negedge clk) begin
    if (!done && checks >= 0) begin
      chk(e_rst ? "R1" : "R2",  "hs",    int'(hs_o),    e_hs);
      chk(e_rst ? "R1" : "R5",  "vs",    int'(vs_o),    e_vs);
      chk(e_rst ? "R1" : e_ltag, "lv",   int'(lv_o),    e_lv);
      chk(e_rst ? "R1" : e_ltag, "line", int'(line_o),  e_line);
      chk(e_rst ? "R1" : "R5",  "field", int'(field_o), e_field);
      chk(e_rst ? "R1" : "R7",  "fast",  int'(fast_o),  e_fast);
      chk(e_rst ? "R1" : "R9",  "hdum",  int'(hdum_o),  e_hdum);
      chk(e_rst ? "R1" : "R10", "hwin",  int'(hwin_o),  e_hwin);
      chk(e_rst ? "R1" : "R10", "hob",   int'(hob_o),   e_hob);
      chk(e_rst ? "R1" : "R11", "vob",   int'(vob_o),   e_vob);
      chk(e_rst ? "R1" : "R4",  "vdum",  int'(vdum_o),  e_vdum);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R3 R4 R5: two full frames
    repeat (2 * 2 * FDL * LC) @(negedge clk);
    // R7: fast requested mid-field, R6 fast frames, R2 with zero sync
    repeat (100) @(negedge clk);
    fast_sel = 1'b1;
    hs_width = '0;
    repeat (4 * FL * LC) @(negedge clk);
    // R7: back to full mid-field, R2 sync covering whole line
    repeat (70) @(negedge clk);
    fast_sel = 1'b0;
    hs_width = (PXW+1)'(LC);
    repeat (3 * FDL * LC) @(negedge clk);
    // R1: reset mid-field while fast is requested
    hs_width = (PXW+1)'(7);
    fast_sel = 1'b1;
    repeat (33) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (2 * FDL * LC + 3 * FL * LC) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule